// File: doc/BRIEF.md
# Console UART Register Bank

This block is the programmer-facing side of a small console UART. A word-addressed bus reaches a set of byte-wide control and status registers, a 16-bit baud divisor, and two byte FIFOs. The serial shifters sit outside the block. The receive shifter pushes finished characters in through `rx_push_i`. The transmit shifter takes characters out through `tx_valid_o` and `tx_pop_i`, and reports through `tx_busy_i` that it is still sending a frame.

Bus reads are combinational. `rdata_o` shows the addressed register during a read request. Side effects of an access (a FIFO pop, clearing the overrun flag, a register update) take place at the clock edge that ends the request. The module-enable input gates the whole block. While it is low the block behaves as if it were absent, and as soon as it rises the receive side can accept characters.

A divisor-latch bit in the line-control register swaps the data register over to the low byte of the baud divisor. Software uses this to program the divisor through the data register alone. When the bit is clear, the same data register is the FIFO port.

Top module: `cuart_regs`

## Requirements
- R1: After reset the registers read as follows, provided the shifter is idle. Line status reads 0x60, extra control reads 0x03, interrupt identify reads 0x01, and interrupt enable, line control and baud read 0. `irq_o` is low.
- R2: The byte offsets are 0x40 data, 0x44 interrupt enable (bits 1:0), 0x48 interrupt identify, 0x4C line control (bit 7 divisor latch, bit 6 break, bit 0 eight-bit mode; other bits read 0), 0x50 modem control (bit 1 only, shown on `rts_req_o`), 0x54 line status, 0x58 modem status (reads 0), 0x5C scratch (8-bit store), 0x60 extra control, 0x64 extra status, and 0x68 baud (16 bits, shown on `baud_div_o`).
- R3: While line-control bit 7 is set, a write to the data register updates baud bits 7:0 and a read of it returns them. Neither FIFO changes.
- R4: While line-control bit 7 is clear, a data write pushes bits 7:0 into the transmit FIFO, and the write is dropped when the FIFO is full. A data read returns the oldest received byte and removes it. When the receive FIFO is empty the read returns 0 and has no effect.
- R5: In line status, bit 0 means the receive FIFO is non-empty and bit 5 means the transmit FIFO is not full. Bit 6 means the transmit FIFO is empty and `tx_busy_i` is low.
- R6: A character pushed while the receive FIFO is full is discarded and sets line-status bit 1. Any line-status read clears that bit. If a new overrun arrives in the same cycle as a read, the flag stays set.
- R7: Extra status (0x64) reports the overrun flag in bit 0, the receive FIFO level in bits 8 and up, and the transmit FIFO level in bits 16 and up. Reading it clears nothing.
- R8: `irq_o` is high when interrupt-enable bit 0 is set and the receive FIFO is non-empty. It is also high when interrupt-enable bit 1 is set and the transmit FIFO is empty. In all other cases it is low.
- R9: Interrupt identify reads 0x04 for a pending receive source, 0x02 for a pending transmit source with no receive source pending, and 0x01 when nothing is pending. Receive wins when both are pending.
- R10: While `module_en_i` is low the block is shut off. Writes are ignored, reads return 0 with no side effect, `rx_push_i` is ignored, and `tx_valid_o` and `irq_o` stay low.
- R11: Extra-control bit 1 enables the transmitter: `tx_valid_o` can rise only while it is set. Bit 0 enables the receiver: `rx_push_i` is ignored while it is clear. Bits 1 and 0 drive `tx_en_o` and `rx_en_o`, and bits 7:2 drive `flow_cfg_o`.
- R12: `tx_valid_o` is high while the transmit FIFO holds a byte. In that state `tx_data_o` is the oldest byte, and `tx_pop_i` removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| module_en_i | input | 1 | Global enable of the UART |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, 0 when no read is active |
| irq_o | output | 1 | Combined interrupt |
| rx_push_i | input | 1 | Receive shifter delivers a character |
| rx_data_i | input | 8 | Received character |
| tx_busy_i | input | 1 | Transmit shifter is sending a frame |
| tx_pop_i | input | 1 | Transmit shifter takes the head byte |
| tx_valid_o | output | 1 | A byte is ready for the transmit shifter |
| tx_data_o | output | 8 | Head byte of the transmit FIFO |
| baud_div_o | output | 16 | Baud divisor |
| tx_en_o | output | 1 | Transmitter enable |
| rx_en_o | output | 1 | Receiver enable |
| data8_o | output | 1 | Eight-bit character mode |
| break_o | output | 1 | Hold the transmit line low |
| rts_req_o | output | 1 | Software request-to-send bit |
| flow_cfg_o | output | 6 | Flow-control settings for the pin logic |

## Verification
The bench drives an overrun into a full receive FIFO three ways: on its own, with extra-status reads in between, and in the same cycle as a line-status read. A design that clears the flag on any status read, or that lets the read win the race, loses the error indication. It toggles the divisor-latch bit around data accesses. A design with a wrong mux would push a baud byte into the transmit FIFO or pop a received character. It also writes past a full transmit FIFO, reads an empty receive FIFO, and drops the module enable. A design with weak gating would let the extra byte overwrite data, return stale data, or accept traffic while shut off.

// File: rtl/cuart_pkg.sv
package cuart_pkg;
  localparam logic [7:0] OFF_DATA = 8'h40;
  localparam logic [7:0] OFF_IER  = 8'h44;
  localparam logic [7:0] OFF_IIR  = 8'h48;
  localparam logic [7:0] OFF_LCR  = 8'h4C;
  localparam logic [7:0] OFF_MCR  = 8'h50;
  localparam logic [7:0] OFF_LSR  = 8'h54;
  localparam logic [7:0] OFF_MSR  = 8'h58;
  localparam logic [7:0] OFF_SCR  = 8'h5C;
  localparam logic [7:0] OFF_CTL  = 8'h60;
  localparam logic [7:0] OFF_STAT = 8'h64;
  localparam logic [7:0] OFF_BAUD = 8'h68;

  localparam logic [7:0] CTL_RESET = 8'h03;

  typedef struct packed {
    logic dlab;
    logic brk;
    logic d8;
  } line_ctl_t;
endpackage

// File: rtl/cuart_fifo.sv
module cuart_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic [CW-1:0]    count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  // full/empty judged on the level at the start of the cycle
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  assign data_o  = mem_q[rd_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/cuart_status.sv
module cuart_status (
  input  logic       en_i,
  input  logic       rx_empty_i,
  input  logic       tx_empty_i,
  input  logic       tx_full_i,
  input  logic       tx_busy_i,
  input  logic       ovr_i,
  input  logic [1:0] ier_i,
  output logic [7:0] lsr_o,
  output logic [7:0] iir_o,
  output logic       irq_o
);
  logic rx_pend, tx_pend;

  assign rx_pend = ier_i[0] && !rx_empty_i;
  assign tx_pend = ier_i[1] && tx_empty_i;

  assign lsr_o = {1'b0, tx_empty_i && !tx_busy_i, !tx_full_i, 3'b000, ovr_i, !rx_empty_i};
  // receive source takes priority
  assign iir_o = {5'b0, rx_pend, tx_pend && !rx_pend, !(rx_pend || tx_pend)};
  assign irq_o = en_i && (rx_pend || tx_pend);
endmodule

// File: rtl/cuart_regs.sv
module cuart_regs
  import cuart_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned FIFO_DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              module_en_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  input  logic              rx_push_i,
  input  logic [7:0]        rx_data_i,
  input  logic              tx_busy_i,
  input  logic              tx_pop_i,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic [15:0]       baud_div_o,
  output logic              tx_en_o,
  output logic              rx_en_o,
  output logic              data8_o,
  output logic              break_o,
  output logic              rts_req_o,
  output logic [5:0]        flow_cfg_o
);
  localparam int unsigned CW = $clog2(FIFO_DEPTH + 1);

  // register state
  logic [1:0]  ier_q;
  line_ctl_t   lcr_q;
  logic        rts_q;
  logic [7:0]  scr_q;
  logic [7:0]  ctl_q;
  logic [15:0] baud_q;
  logic        ovr_q;

  // fifo signals
  logic          tx_push, tx_pop, tx_full, tx_empty;
  logic          rx_acc, rx_pop, rx_full, rx_empty;
  logic [7:0]    tx_head, rx_head;
  logic [CW-1:0] tx_cnt, rx_cnt;

  // decode
  logic rd_en, wr_en;
  logic hit_data, hit_ier, hit_iir, hit_lcr, hit_mcr, hit_lsr;
  logic hit_msr, hit_scr, hit_ctl, hit_stat, hit_baud;
  logic ovr_evt;
  logic [7:0] lsr, iir;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i[31:16];

  assign rd_en = req_i && !we_i && module_en_i;
  assign wr_en = req_i && we_i && module_en_i;

  assign hit_data = (addr_i == ADDR_W'(OFF_DATA));
  assign hit_ier  = (addr_i == ADDR_W'(OFF_IER));
  assign hit_iir  = (addr_i == ADDR_W'(OFF_IIR));
  assign hit_lcr  = (addr_i == ADDR_W'(OFF_LCR));
  assign hit_mcr  = (addr_i == ADDR_W'(OFF_MCR));
  assign hit_lsr  = (addr_i == ADDR_W'(OFF_LSR));
  assign hit_msr  = (addr_i == ADDR_W'(OFF_MSR));
  assign hit_scr  = (addr_i == ADDR_W'(OFF_SCR));
  assign hit_ctl  = (addr_i == ADDR_W'(OFF_CTL));
  assign hit_stat = (addr_i == ADDR_W'(OFF_STAT));
  assign hit_baud = (addr_i == ADDR_W'(OFF_BAUD));

  // data port steering
  assign tx_push = wr_en && hit_data && !lcr_q.dlab;
  assign rx_pop  = rd_en && hit_data && !lcr_q.dlab;

  assign rx_acc  = module_en_i && ctl_q[0] && rx_push_i;
  assign ovr_evt = rx_acc && rx_full;

  assign tx_valid_o = module_en_i && ctl_q[1] && !tx_empty;
  assign tx_pop     = tx_pop_i && tx_valid_o;
  assign tx_data_o  = tx_head;

  cuart_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (tx_push),
    .data_i  (wdata_i[7:0]),
    .pop_i   (tx_pop),
    .data_o  (tx_head),
    .count_o (tx_cnt),
    .full_o  (tx_full),
    .empty_o (tx_empty)
  );

  cuart_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rx_acc),
    .data_i  (rx_data_i),
    .pop_i   (rx_pop),
    .data_o  (rx_head),
    .count_o (rx_cnt),
    .full_o  (rx_full),
    .empty_o (rx_empty)
  );

  cuart_status status_i (
    .en_i       (module_en_i),
    .rx_empty_i (rx_empty),
    .tx_empty_i (tx_empty),
    .tx_full_i  (tx_full),
    .tx_busy_i  (tx_busy_i),
    .ovr_i      (ovr_q),
    .ier_i      (ier_q),
    .lsr_o      (lsr),
    .iir_o      (iir),
    .irq_o      (irq_o)
  );

  // control registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ier_q  <= '0;
      lcr_q  <= '0;
      rts_q  <= 1'b0;
      scr_q  <= '0;
      ctl_q  <= CTL_RESET;
      baud_q <= '0;
    end else if (wr_en) begin
      if (hit_ier) ier_q <= wdata_i[1:0];
      if (hit_lcr) lcr_q <= '{dlab: wdata_i[7], brk: wdata_i[6], d8: wdata_i[0]};
      if (hit_mcr) rts_q <= wdata_i[1];
      if (hit_scr) scr_q <= wdata_i[7:0];
      if (hit_ctl) ctl_q <= wdata_i[7:0];
      if (hit_baud) baud_q <= wdata_i[15:0];
      else if (hit_data && lcr_q.dlab) baud_q[7:0] <= wdata_i[7:0];
    end
  end

  // overrun: a new event beats the read-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovr_q <= 1'b0;
    else if (ovr_evt) ovr_q <= 1'b1;
    else if (rd_en && hit_lsr) ovr_q <= 1'b0;
  end

  // read mux
  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      unique case (1'b1)
        hit_data: rdata_o[7:0] = lcr_q.dlab ? baud_q[7:0] : (rx_empty ? 8'h00 : rx_head);
        hit_ier:  rdata_o[1:0] = ier_q;
        hit_iir:  rdata_o[7:0] = iir;
        hit_lcr:  rdata_o[7:0] = {lcr_q.dlab, lcr_q.brk, 5'b0, lcr_q.d8};
        hit_mcr:  rdata_o[7:0] = {6'b0, rts_q, 1'b0};
        hit_lsr:  rdata_o[7:0] = lsr;
        hit_msr:  rdata_o = '0;
        hit_scr:  rdata_o[7:0] = scr_q;
        hit_ctl:  rdata_o[7:0] = ctl_q;
        hit_stat: begin
          rdata_o[0]       = ovr_q;
          rdata_o[8 +: CW]  = rx_cnt;
          rdata_o[16 +: CW] = tx_cnt;
        end
        hit_baud: rdata_o[15:0] = baud_q;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign baud_div_o = baud_q;
  assign tx_en_o    = ctl_q[1];
  assign rx_en_o    = ctl_q[0];
  assign flow_cfg_o = ctl_q[7:2];
  assign data8_o    = lcr_q.d8;
  assign break_o    = lcr_q.brk;
  assign rts_req_o  = rts_q;
endmodule

// File: rtl/cuart_regs_chk.sv
module cuart_regs_chk
  import cuart_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned FIFO_DEPTH = 8,
  localparam int unsigned CW = $clog2(FIFO_DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              module_en_i,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_lo,
  input logic [31:0]       rdata_o,
  input logic              irq_o,
  input logic              tx_en_o,
  input logic              tx_valid_o,
  input logic              tx_busy_i,
  input logic [15:0]       baud_div_o,
  input logic              dlab,
  input logic              ovr_q,
  input logic              ovr_evt,
  input logic [CW-1:0]     tx_cnt
);
  logic lsr_rd, data_wr;
  assign lsr_rd  = req_i && !we_i && module_en_i && (addr_i == ADDR_W'(OFF_LSR));
  assign data_wr = req_i && we_i && module_en_i && (addr_i == ADDR_W'(OFF_DATA));

  assert_gate_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !module_en_i |-> (!irq_o && rdata_o == 32'h0 && !tx_valid_o));

  assert_tx_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_o |-> !tx_valid_o);

  assert_ovr_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_evt |=> ovr_q);

  assert_ovr_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_rd && !ovr_evt) |=> !ovr_q);

  assert_dlab_baud_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && dlab) |=> (baud_div_o[7:0] == $past(wdata_lo)));

  assert_lsr_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lsr_rd |-> (rdata_o[6] == (tx_cnt == '0 && !tx_busy_i)));

  assert_tx_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(tx_cnt) <= FIFO_DEPTH);
endmodule

bind cuart_regs cuart_regs_chk #(.ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .module_en_i (module_en_i),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_lo    (wdata_i[7:0]),
  .rdata_o     (rdata_o),
  .irq_o       (irq_o),
  .tx_en_o     (tx_en_o),
  .tx_valid_o  (tx_valid_o),
  .tx_busy_i   (tx_busy_i),
  .baud_div_o  (baud_div_o),
  .dlab        (lcr_q.dlab),
  .ovr_q       (ovr_q),
  .ovr_evt     (ovr_evt),
  .tx_cnt      (tx_cnt)
);

// File: tb/cuart_regs_tb_top.sv
module cuart_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int D = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        rx_push = 1'b0, tx_busy = 1'b0, tx_pop = 1'b0;
  logic [7:0]  rx_data = '0;

  logic [31:0] rdata_o;
  logic        irq_o, tx_valid_o, tx_en_o, rx_en_o, data8_o, break_o, rts_req_o;
  logic [7:0]  tx_data_o;
  logic [15:0] baud_div_o;
  logic [5:0]  flow_cfg_o;

  cuart_regs #(.ADDR_W(8), .FIFO_DEPTH(D)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .module_en_i(en), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_o), .irq_o(irq_o),
    .rx_push_i(rx_push), .rx_data_i(rx_data), .tx_busy_i(tx_busy), .tx_pop_i(tx_pop),
    .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .baud_div_o(baud_div_o),
    .tx_en_o(tx_en_o), .rx_en_o(rx_en_o), .data8_o(data8_o), .break_o(break_o),
    .rts_req_o(rts_req_o), .flow_cfg_o(flow_cfg_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] last_rd;

  // reference model
  logic [7:0]  rxq[$];
  logic [7:0]  txq[$];
  logic [1:0]  m_ier;
  logic [7:0]  m_lcr, m_mcr, m_scr, m_ctl;
  logic [15:0] m_baud;
  logic        m_ovr;

  task automatic m_reset();
    rxq.delete(); txq.delete();
    m_ier = '0; m_lcr = '0; m_mcr = '0; m_scr = '0; m_ctl = 8'h03; m_baud = '0; m_ovr = 1'b0;
  endtask

  task automatic m_step();
    bit rd, wr, dl, rx_take, ev;
    int rxn, txn;
    rd = req && !we && en;
    wr = req && we && en;
    dl = m_lcr[7];
    rxn = rxq.size();
    txn = txq.size();
    rx_take = en && m_ctl[0] && rx_push;
    ev = rx_take && (rxn == D);
    if (en && m_ctl[1] && txn > 0 && tx_pop) void'(txq.pop_front());
    if (wr && addr == 8'h40 && !dl && txn < D) txq.push_back(wdata[7:0]);
    if (rd && addr == 8'h40 && !dl && rxn > 0) void'(rxq.pop_front());
    if (rx_take && rxn < D) rxq.push_back(rx_data);
    if (ev) m_ovr = 1'b1;
    else if (rd && addr == 8'h54) m_ovr = 1'b0;
    if (wr) begin
      case (addr)
        8'h40: if (dl) m_baud[7:0] = wdata[7:0];
        8'h44: m_ier = wdata[1:0];
        8'h4C: m_lcr = wdata[7:0] & 8'hC1;
        8'h50: m_mcr = wdata[7:0] & 8'h02;
        8'h5C: m_scr = wdata[7:0];
        8'h60: m_ctl = wdata[7:0];
        8'h68: m_baud = wdata[15:0];
        default: ;
      endcase
    end
  endtask

  initial m_reset();
  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else m_step();
  end

  function automatic logic [31:0] exp_rd();
    logic [31:0] r;
    r = '0;
    if (!(req && !we && en)) return r;
    case (addr)
      8'h40: r[7:0] = m_lcr[7] ? m_baud[7:0] : (rxq.size() > 0 ? rxq[0] : 8'h00);
      8'h44: r[1:0] = m_ier;
      8'h48: r[7:0] = (m_ier[0] && rxq.size() > 0) ? 8'h04 :
                      (m_ier[1] && txq.size() == 0) ? 8'h02 : 8'h01;
      8'h4C: r[7:0] = m_lcr;
      8'h50: r[7:0] = m_mcr;
      8'h54: r[7:0] = {1'b0, txq.size() == 0 && !tx_busy, txq.size() < D, 3'b000, m_ovr, rxq.size() > 0};
      8'h5C: r[7:0] = m_scr;
      8'h60: r[7:0] = m_ctl;
      8'h64: begin
        r[0] = m_ovr;
        r[15:8] = 8'(rxq.size());
        r[23:16] = 8'(txq.size());
      end
      8'h68: r[15:0] = m_baud;
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string rd_tag();
    if (!en) return "R10";
    case (addr)
      8'h40: return m_lcr[7] ? "R3" : "R4";
      8'h48: return "R9";
      8'h54: return "R5";
      8'h60: return "R11";
      8'h64: return "R7";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp();
    bit txv, irq;
    txv = en && m_ctl[1] && txq.size() > 0;
    irq = en && ((m_ier[0] && rxq.size() > 0) || (m_ier[1] && txq.size() == 0));
    chk(rd_tag(), rdata_o, exp_rd());
    chk("R8", 32'(irq_o), 32'(irq));
    chk("R12", 32'(tx_valid_o), 32'(txv));
    if (txv) chk("R12", 32'(tx_data_o), 32'(txq[0]));
    chk("R2", 32'(baud_div_o), 32'(m_baud));
    chk("R11", 32'({flow_cfg_o, tx_en_o, rx_en_o}), 32'(m_ctl));
    chk("R2", 32'({data8_o, break_o, rts_req_o}), 32'({m_lcr[0], m_lcr[6], m_mcr[1]}));
  endtask

  task automatic cyc();
    #1;
    cmp();
    last_rd = rdata_o;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0; rx_push = 1'b0; tx_pop = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    cyc();
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    req = 1'b1; we = 1'b0; addr = a;
    cyc();
    v = last_rd;
  endtask

  task automatic rxin(input logic [7:0] b);
    rx_push = 1'b1; rx_data = b;
    cyc();
  endtask

  task automatic txtake(output logic [7:0] b);
    tx_pop = 1'b1;
    #1 b = tx_data_o;
    cyc();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    en = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h54, v); chk("R1", v, 32'h60);
    rd(8'h60, v); chk("R1", v, 32'h03);
    rd(8'h48, v); chk("R1", v, 32'h01);
    rd(8'h44, v); chk("R1", v, 32'h00);
    rd(8'h4C, v); chk("R1", v, 32'h00);
    rd(8'h68, v); chk("R1", v, 32'h00);
    chk("R1", 32'(irq_o), 32'h0);

    // R2 plain registers
    wr(8'h5C, 32'hA5); rd(8'h5C, v); chk("R2", v, 32'hA5);
    wr(8'h50, 32'hFF); rd(8'h50, v); chk("R2", v, 32'h02);
    wr(8'h4C, 32'h3E); rd(8'h4C, v); chk("R2", v, 32'h00);
    wr(8'h4C, 32'h41); rd(8'h4C, v); chk("R2", v, 32'h41);
    wr(8'h68, 32'hBEEF1234); rd(8'h68, v); chk("R2", v, 32'h1234);
    rd(8'h58, v); chk("R2", v, 32'h0);

    // R3 divisor latch steering
    wr(8'h4C, 32'h81);
    wr(8'h40, 32'h5A);
    rd(8'h40, v); chk("R3", v, 32'h5A);
    rd(8'h68, v); chk("R3", v, 32'h125A);
    rd(8'h64, v); chk("R3", v, 32'h0);
    wr(8'h4C, 32'h01);

    // R4 / R12 transmit path, overflow of the transmit FIFO
    for (int i = 0; i < D + 2; i++) wr(8'h40, 32'hA0 + i);
    rd(8'h64, v); chk("R4", v, 32'(D) << 16);
    rd(8'h54, v); chk("R5", v, 32'h00);
    for (int i = 0; i < D; i++) begin
      txtake(b); chk("R12", 32'(b), 32'hA0 + i);
    end
    chk("R12", 32'(tx_valid_o), 32'h0);
    tx_busy = 1'b1;
    rd(8'h54, v); chk("R5", v, 32'h20);
    tx_busy = 1'b0;
    rd(8'h54, v); chk("R5", v, 32'h60);

    // R6 / R7 overrun
    for (int i = 0; i < D; i++) rxin(8'h10 + i);
    rxin(8'h99);
    rd(8'h64, v); chk("R7", v, (32'(D) << 8) | 32'h1);
    rd(8'h64, v); chk("R7", v, (32'(D) << 8) | 32'h1);
    rd(8'h54, v); chk("R6", v, 32'h63);
    rd(8'h54, v); chk("R6", v, 32'h61);
    rx_push = 1'b1; rx_data = 8'h77;
    rd(8'h54, v); chk("R6", v, 32'h61);
    rd(8'h54, v); chk("R6", v, 32'h63);
    for (int i = 0; i < D; i++) begin
      rd(8'h40, v); chk("R4", v, 32'h10 + i);
    end
    rd(8'h40, v); chk("R4", v, 32'h0);
    rd(8'h64, v); chk("R7", v, 32'h0);

    // R8 / R9 interrupts
    wr(8'h44, 32'h1);
    chk("R8", 32'(irq_o), 32'h0);
    rxin(8'h42);
    chk("R8", 32'(irq_o), 32'h1);
    rd(8'h48, v); chk("R9", v, 32'h04);
    wr(8'h44, 32'h3);
    rd(8'h48, v); chk("R9", v, 32'h04);
    rd(8'h40, v); chk("R4", v, 32'h42);
    rd(8'h48, v); chk("R9", v, 32'h02);
    chk("R8", 32'(irq_o), 32'h1);
    wr(8'h40, 32'h33);
    chk("R8", 32'(irq_o), 32'h0);
    txtake(b); chk("R12", 32'(b), 32'h33);
    wr(8'h44, 32'h0);
    rd(8'h48, v); chk("R9", v, 32'h01);

    // R10 module disabled
    en = 1'b0;
    wr(8'h5C, 32'h11);
    rxin(8'h55);
    wr(8'h40, 32'h66);
    rd(8'h5C, v); chk("R10", v, 32'h0);
    chk("R10", 32'(tx_valid_o), 32'h0);
    en = 1'b1;
    rd(8'h5C, v); chk("R10", v, 32'hA5);
    rd(8'h64, v); chk("R10", v, 32'h0);

    // R11 enables
    wr(8'h60, 32'h00);
    rxin(8'h21);
    rd(8'h64, v); chk("R11", v, 32'h0);
    wr(8'h40, 32'h44);
    chk("R11", 32'(tx_valid_o), 32'h0);
    wr(8'h60, 32'hFF);
    chk("R11", 32'(flow_cfg_o), 32'h3F);
    chk("R11", 32'(tx_valid_o), 32'h1);
    txtake(b); chk("R12", 32'(b), 32'h44);
    rxin(8'h21);
    rd(8'h40, v); chk("R11", v, 32'h21);

    repeat (2) cyc();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule